// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table held in memory and does not cache any entries. A request carries three things: the virtual address, a flag that says whether the access comes from user mode or supervisor mode, and the kind of access (load, store or instruction fetch). The walker records the request together with the root-table base that is applied at its input. It then makes at most two word reads on a simple memory port. The first read fetches the directory entry and the second fetches the leaf entry. It finishes with a single result pulse that carries either a physical address or a fault cause.

The virtual address is split into three fields. The top ten bits select one of 1,024 directory entries, and each of those entries covers 4 MB. The next ten bits select one of 1,024 leaf entries, and each leaf entry maps one 4 KB page. The low twelve bits are the byte offset within the page. Every entry is one 32-bit word, laid out as follows:

| Bits | Meaning |
|------|---------|
| 0 | valid |
| 1 | supervisor-only |
| 2 | writable |
| 3 | executable |
| 31:12 | frame number, or base of the next table |

The walker accepts one request at a time.

Top module: `two_level_walker`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1, and both `res_valid` and `mem_req_valid` are 0.
- R2: The first read address is {root_base[31:12], 12'h000} + va[31:22]*4. The second read address is {dir_entry[31:12], 12'h000} + va[21:12]*4.
- R3: A successful walk returns `res_paddr` = {leaf[31:12], va[11:0]}, together with `res_fault` = 0 and `res_cause` = 0.
- R4: A directory entry with bit 0 clear ends the walk after a single read. The result is `res_fault` = 1 and `res_cause` = 1.
- R5: A leaf entry with bit 0 clear gives `res_fault` = 1 and `res_cause` = 2.
- R6: A user-mode request (`req_user` = 1) to a leaf whose bit 1 is set gives cause 3. A supervisor-mode request (`req_user` = 0) is not restricted by bit 1.
- R7: A store (`req_acc` = 1) to a leaf whose bit 2 is clear gives cause 3.
- R8: A fetch (`req_acc` = 2) from a leaf whose bit 3 is clear gives cause 3. A load (`req_acc` = 0) needs neither bit 2 nor bit 3.
- R9: `req_ready` is 0 from the cycle after acceptance until the result pulse. Requests offered during that time are ignored.
- R10: `res_valid` is high for exactly one cycle. `mem_req_valid` is high for one cycle per read. A walk makes no more than two reads.
- R11: `root_base` is sampled when the request is accepted. A change to it during a walk has no effect on that walk.
- R12: On any fault, `res_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, able to accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| root_base | input | 32 | Directory base; bits 31:12 are used |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 32 | Word address of the entry to read |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | 32 | Entry word returned |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault | output | 1 | Translation failed |
| res_cause | output | 2 | 0 none, 1 directory invalid, 2 leaf invalid, 3 permission |
| res_paddr | output | 32 | Physical address, or 0 on a fault |

## Verification
The bench builds the walker with the package defaults: 32-bit addresses, ten-bit indices and a 4 KB page. Those defaults keep the walks small enough to write out by hand. They let two directories and two leaf tables sit in a sparse memory model, with non-zero values in every index field and in the page offset. The memory model answers after one to three cycles, so the wait states are exercised at several response latencies. Each combination of mode and access kind is driven against leaves with different permission bits. This covers every fault cause, the early stop on an empty directory entry, and a root base that changes in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    parameter int VA_W  = 32;
    parameter int PA_W  = 32;
    parameter int OFF_W = 12;
    parameter int IDX_W = 10;

    localparam int PFN_W  = PA_W - OFF_W;
    localparam int RSVD_W = OFF_W - 4;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_L1_INV = 2'd1,
        CAUSE_L2_INV = 2'd2,
        CAUSE_PERM   = 2'd3
    } cause_e;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [RSVD_W-1:0] rsvd;
        logic              exe;
        logic              wr;
        logic              sup;
        logic              valid;
    } pte_t;

    function automatic logic [PA_W-1:0] entry_addr(
        input logic [PFN_W-1:0] base,
        input logic [IDX_W-1:0] idx
    );
        logic [PA_W-1:0] scaled;
        scaled = {{(PA_W-IDX_W-2){1'b0}}, idx, 2'b00};
        return {base, {OFF_W{1'b0}}} + scaled;
    endfunction
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    output logic [IDX_W-1:0] dir_idx,
    output logic [IDX_W-1:0] leaf_idx,
    output logic [OFF_W-1:0] offset
);
    localparam int LEAF_LO = OFF_W;
    localparam int DIR_LO  = OFF_W + IDX_W;

    assign offset   = va[OFF_W-1:0];
    assign leaf_idx = va[LEAF_LO +: IDX_W];
    assign dir_idx  = va[DIR_LO +: IDX_W];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic             second_level,
    input  logic [PFN_W-1:0] root_pfn,
    input  logic [PFN_W-1:0] table_pfn,
    input  logic [IDX_W-1:0] dir_idx,
    input  logic [IDX_W-1:0] leaf_idx,
    output logic [PA_W-1:0]  addr
);
    always_comb begin
        if (second_level)
            addr = entry_addr(table_pfn, leaf_idx);
        else
            addr = entry_addr(root_pfn, dir_idx);
    end
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
    import ptw_pkg::*;
(
    input  pte_t   leaf,
    input  logic   user_mode,
    input  acc_e   acc,
    output cause_e cause
);
    logic deny_mode, deny_store, deny_fetch;
    logic unused_leaf;

    assign unused_leaf = ^{leaf.pfn, leaf.rsvd};
    assign deny_mode   = user_mode & leaf.sup;
    assign deny_store  = (acc == ACC_STORE) & ~leaf.wr;
    assign deny_fetch  = (acc == ACC_FETCH) & ~leaf.exe;

    always_comb begin
        if (!leaf.valid)
            cause = CAUSE_L2_INV;
        else if (deny_mode | deny_store | deny_fetch)
            cause = CAUSE_PERM;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/two_level_walker.sv
module two_level_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_user,
    input  logic [1:0]  req_acc,
    input  logic [31:0] root_base,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_resp_valid,
    input  logic [31:0] mem_resp_data,
    output logic        res_valid,
    output logic        res_fault,
    output logic [1:0]  res_cause,
    output logic [31:0] res_paddr
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_LEAF_REQ, ST_LEAF_WAIT, ST_DONE
    } state_e;

    state_e           state;
    logic [VA_W-1:0]  va_q;
    logic             user_q;
    acc_e             acc_q;
    logic [PFN_W-1:0] root_q;
    logic [PFN_W-1:0] table_q;
    cause_e           cause_q;
    logic [PA_W-1:0]  pa_q;

    logic [IDX_W-1:0] dir_idx, leaf_idx;
    logic [OFF_W-1:0] offset;
    pte_t             resp_pte;
    cause_e           leaf_cause;
    logic             unused_root;

    assign resp_pte    = pte_t'(mem_resp_data);
    assign unused_root = ^root_base[OFF_W-1:0];

    ptw_va_split u_split (
        .va       (va_q),
        .dir_idx  (dir_idx),
        .leaf_idx (leaf_idx),
        .offset   (offset)
    );

    ptw_addr_gen u_addr (
        .second_level (state == ST_LEAF_REQ),
        .root_pfn     (root_q),
        .table_pfn    (table_q),
        .dir_idx      (dir_idx),
        .leaf_idx     (leaf_idx),
        .addr         (mem_req_addr)
    );

    ptw_leaf_check u_check (
        .leaf      (resp_pte),
        .user_mode (user_q),
        .acc       (acc_q),
        .cause     (leaf_cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            user_q  <= 1'b0;
            acc_q   <= ACC_LOAD;
            root_q  <= '0;
            table_q <= '0;
            cause_q <= CAUSE_NONE;
            pa_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    user_q <= req_user;
                    acc_q  <= acc_e'(req_acc);
                    root_q <= root_base[PA_W-1:OFF_W];
                    state  <= ST_DIR_REQ;
                end
                ST_DIR_REQ: state <= ST_DIR_WAIT;
                ST_DIR_WAIT: if (mem_resp_valid) begin
                    if (!resp_pte.valid) begin
                        cause_q <= CAUSE_L1_INV;
                        pa_q    <= '0;
                        state   <= ST_DONE;
                    end else begin
                        table_q <= resp_pte.pfn;
                        state   <= ST_LEAF_REQ;
                    end
                end
                ST_LEAF_REQ: state <= ST_LEAF_WAIT;
                ST_LEAF_WAIT: if (mem_resp_valid) begin
                    cause_q <= leaf_cause;
                    pa_q    <= (leaf_cause == CAUSE_NONE) ? {resp_pte.pfn, offset} : '0;
                    state   <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_DIR_REQ) || (state == ST_LEAF_REQ);
    assign res_valid     = (state == ST_DONE);
    assign res_cause     = cause_q;
    assign res_fault     = (cause_q != CAUSE_NONE);
    assign res_paddr     = pa_q;

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R10
    mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R4
    dir_invalid_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIR_WAIT && mem_resp_valid && !mem_resp_data[0])
        |=> (res_valid && res_cause == 2'd1 && !mem_req_valid));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_fault) |-> (res_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

    // R12
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault) |-> (res_paddr == '0));
endmodule

// File: tb/tb_two_level_walker.sv
module tb_two_level_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        req_user;
    logic [1:0]  req_acc;
    logic [31:0] root_base;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid;
    logic [31:0] mem_resp_data;
    logic        res_valid;
    logic        res_fault;
    logic [1:0]  res_cause;
    logic [31:0] res_paddr;

    always #5 clk = ~clk;

    two_level_walker dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_user(req_user), .req_acc(req_acc), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause),
        .res_paddr(res_paddr)
    );

    int checks = 0;
    int failures = 0;
    int reads = 0;
    int lat = 1;
    logic [31:0] addr_log [2];
    logic [31:0] mem [logic [31:0]];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: one to three cycles of latency
    initial begin
        mem_resp_valid = 1'b0;
        mem_resp_data  = '0;
        forever begin
            @(negedge clk);
            mem_resp_valid = 1'b0;
            if (mem_req_valid) begin
                logic [31:0] a;
                a = mem_req_addr;
                if (reads < 2) addr_log[reads] = a;
                reads++;
                repeat (lat) @(negedge clk);
                mem_resp_valid = 1'b1;
                mem_resp_data  = mem.exists(a) ? mem[a] : 32'h0;
            end
        end
    end

    // entry bits: 0 valid, 1 supervisor-only, 2 writable, 3 executable
    initial begin
        mem[32'h0010_0004] = 32'h0020_0001;
        mem[32'h0010_000C] = 32'h0030_0001;
        mem[32'h0020_0014] = 32'hABCD_E00D;
        mem[32'h0020_0018] = 32'h1234_5003;
        mem[32'h0020_0020] = 32'h5555_5005;
        mem[32'h0030_0000] = 32'h7777_700B;
        mem[32'h0050_0004] = 32'h0030_0001;
    end

    task automatic walk(input logic [31:0] va, input logic user, input logic [1:0] acc,
                        input logic [31:0] root, input logic [31:0] root_later,
                        input logic noise, output logic [1:0] cause,
                        output logic [31:0] pa, output logic fault, output int nreads,
                        output int busy_viol, output int pulse_viol);
        int n;
        busy_viol = 0;
        pulse_viol = 0;
        @(negedge clk);
        reads = 0;
        req_valid = 1'b1; req_vaddr = va; req_user = user; req_acc = acc; root_base = root;
        @(negedge clk);
        req_valid = noise;
        req_vaddr = 32'h00C0_0000; req_user = 1'b0; req_acc = 2'd0;
        root_base = root_later;
        n = 0;
        while (!res_valid && n < 100) begin
            if (req_ready) busy_viol++;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        if (!res_valid) begin
            checks++; failures++;
            $display("FAIL R10 actual=no result expected=result pulse");
        end
        cause = res_cause; pa = res_paddr; fault = res_fault;
        @(negedge clk);
        if (res_valid) pulse_viol++;
        nreads = reads;
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        user;
        logic [1:0]  acc;
        logic [1:0]  cause;
        logic [31:0] pa;
        logic [1:0]  nrd;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{32'h0040_5123, 1'b1, 2'd0, 2'd0, 32'hABCD_E123, 2'd2},  // R3 user load
        '{32'h0040_5123, 1'b1, 2'd1, 2'd0, 32'hABCD_E123, 2'd2},  // R7 store allowed
        '{32'h0040_5FFF, 1'b1, 2'd2, 2'd0, 32'hABCD_EFFF, 2'd2},  // R8 fetch allowed
        '{32'h0040_6FFF, 1'b1, 2'd0, 2'd3, 32'h0,         2'd2},  // R6 user on supervisor page
        '{32'h0040_6FFF, 1'b0, 2'd0, 2'd0, 32'h1234_5FFF, 2'd2},  // R6 supervisor allowed
        '{32'h0040_6000, 1'b0, 2'd1, 2'd3, 32'h0,         2'd2},  // R7 store to read-only
        '{32'h0040_7010, 1'b0, 2'd0, 2'd2, 32'h0,         2'd2},  // R5 leaf invalid
        '{32'h0080_0ABC, 1'b1, 2'd0, 2'd1, 32'h0,         2'd1},  // R4 directory empty
        '{32'h0040_8004, 1'b1, 2'd2, 2'd3, 32'h0,         2'd2},  // R8 fetch from no-exec
        '{32'h0040_8004, 1'b1, 2'd1, 2'd0, 32'h5555_5004, 2'd2},  // R7 store writable
        '{32'h00C0_0000, 1'b0, 2'd2, 2'd0, 32'h7777_7000, 2'd2},  // R8 fetch executable
        '{32'h00C0_0000, 1'b1, 2'd2, 2'd3, 32'h0,         2'd2}   // R6 user denied
    };

    logic        done = 1'b0;
    logic [1:0]  c;
    logic [31:0] p;
    logic        f;
    int          nr, bv, pv;

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_user = 1'b0; req_acc = '0;
        root_base = 32'h0010_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 res_valid", {31'b0, res_valid}, 32'd0);
        chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);

        for (int i = 0; i < 12; i++) begin
            lat = 1 + (i % 3);
            walk(VECS[i].va, VECS[i].user, VECS[i].acc, 32'h0010_0000, 32'h0010_0000,
                 1'b0, c, p, f, nr, bv, pv);
            chk($sformatf("R3-8 cause vec%0d", i), {30'b0, c}, {30'b0, VECS[i].cause});
            chk($sformatf("R3 R12 paddr vec%0d", i), p, VECS[i].pa);
            chk($sformatf("fault flag vec%0d", i), {31'b0, f}, {31'b0, VECS[i].cause != 2'd0});
            chk($sformatf("R4 R10 reads vec%0d", i), nr, {30'b0, VECS[i].nrd});
            chk($sformatf("R9 busy vec%0d", i), bv, 0);
            chk($sformatf("R10 pulse vec%0d", i), pv, 0);
            if (i == 0) begin
                // R2 entry addresses
                chk("R2 dir addr", addr_log[0], 32'h0010_0004);
                chk("R2 leaf addr", addr_log[1], 32'h0020_0014);
            end
        end

        // R9 requests offered during a walk are ignored
        lat = 2;
        walk(32'h0040_6123, 1'b0, 2'd0, 32'h0010_0000, 32'h0010_0000, 1'b1, c, p, f, nr, bv, pv);
        chk("R9 noisy result", p, 32'h1234_5123);
        chk("R9 noisy reads", nr, 2);
        chk("R9 noisy busy", bv, 0);
        chk("R9 idle after", {31'b0, req_ready}, 32'd1);

        // R11 root change mid-walk has no effect
        lat = 3;
        walk(32'h0040_5010, 1'b1, 2'd0, 32'h0010_0000, 32'h0050_0000, 1'b0, c, p, f, nr, bv, pv);
        chk("R11 root held", p, 32'hABCD_E010);
        chk("R11 dir addr", addr_log[0], 32'h0010_0004);

        // R2 R11 other root selects a different directory
        lat = 1;
        walk(32'h0040_0ABC, 1'b0, 2'd0, 32'h0050_0FFF, 32'h0050_0FFF, 1'b0, c, p, f, nr, bv, pv);
        chk("R2 alt root dir addr", addr_log[0], 32'h0050_0004);
        chk("R2 alt root leaf addr", addr_log[1], 32'h0030_0000);
        chk("R11 alt root result", p, 32'h7777_7ABC);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule